// File: doc/BRIEF.md
# Speculative Store Queue with Graduation

This block holds stores for an out-of-order core from the moment they are allocated until they are written to the data cache. A store takes an entry at dispatch, in program order. Its address and its data are written into that entry later, each on its own fill port, when the store executes. Execution may still be speculative at that point. The core's retirement logic then marks the oldest entries as graduated, up to two per cycle. Only graduated entries are presented on the cache write port, and they leave one per cycle, oldest first. The cache write is the moment a store becomes visible outside the core.

When a mis-speculation is detected, a single flush pulse rewinds the queue to its graduation boundary. Every speculative entry is discarded. Graduated entries are untouched and keep draining. The queue serves two kinds of lookup. A load on this core gives its address and the queue tag it received at dispatch, and gets back the data of the youngest older store to the same address, which may be speculative or graduated. A probe from outside the speculative path, such as another hardware thread, sees graduated entries only.

The cache port is valid/ready. `drain_valid` stays high, and `drain_addr`/`drain_data` stay stable, until `drain_ready` is seen high at a clock edge. While the cache holds `drain_ready` low, allocation goes on until all entries are in use. Allocation is a one-sided handshake: a request is accepted on a clock edge when `alloc_valid` and `alloc_ready` are both high and `flush` is low. Tags carry one extra wrap bit above the entry index.

Top module: `spec_store_queue`

## Requirements
- R1: After reset the queue is empty: `alloc_ready`=1, `full`=0, `drain_valid`=0 and `alloc_tag`=0.
- R2: `alloc_tag` shows the tag the next accepted store receives. Each accepted allocation increments it by one, modulo 2*DEPTH. Its low log2(DEPTH) bits are the entry index used on the fill ports.
- R3: When DEPTH entries are occupied, `full`=1 and `alloc_ready`=0, and an allocation request leaves `alloc_tag` unchanged. A cache port held not ready does not block allocation before that point.
- R4: `retire_cnt` (0, 1 or 2) graduates that many of the oldest speculative entries on the clock edge. Each entry graduated must already hold both its address and its data.
- R5: `drain_valid` is high exactly when the oldest entry is graduated. It then shows that entry's address and data, and the queue advances on a cycle where `drain_valid` and `drain_ready` are both high, so entries leave in allocation order.
- R6: A flush makes `alloc_tag` equal to the graduation boundary on the next cycle. A `retire_cnt` in the same cycle is applied first. Flushed entries never appear on the cache port, and graduated entries still drain.
- R7: An allocation request in the same cycle as a flush is ignored.
- R8: A load lookup returns `fwd_hit`=1 and the data of the youngest entry that is older than its tag, has a filled address and has an equal address. Both speculative and graduated entries count.
- R9: If that youngest matching entry has no data yet, the lookup gives `fwd_stall`=1 and `fwd_hit`=0. Once the data is filled, it hits.
- R10: Entries at or after the load's tag never match, and neither do entries with a different address. A tag outside the occupied window forwards nothing.
- R11: The external probe hits (`rp_hit`=1, with the data of the youngest match) only on graduated entries. A speculative entry with the same address is invisible to it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| alloc_valid | input | 1 | Request to allocate an entry for the next store in program order |
| alloc_ready | output | 1 | Low while all entries are occupied |
| alloc_tag | output | log2(DEPTH)+1 | Tag for the next allocation (index plus wrap bit) |
| st_addr_valid | input | 1 | Write store address into an entry |
| st_addr_idx | input | log2(DEPTH) | Entry index for the address fill |
| st_addr | input | AW | Store address |
| st_data_valid | input | 1 | Write store data into an entry |
| st_data_idx | input | log2(DEPTH) | Entry index for the data fill |
| st_data | input | DW | Store data |
| retire_cnt | input | 2 | Number of oldest stores retiring this cycle (0 to 2) |
| flush | input | 1 | Mis-speculation: discard all speculative entries |
| full | output | 1 | All entries occupied |
| drain_valid | output | 1 | Graduated head entry offered to the cache |
| drain_ready | input | 1 | Cache accepts the offered entry |
| drain_addr | output | AW | Address of the offered entry |
| drain_data | output | DW | Data of the offered entry |
| ld_valid | input | 1 | Load lookup request |
| ld_tag | input | log2(DEPTH)+1 | Queue tag the load received at dispatch |
| ld_addr | input | AW | Load address |
| fwd_hit | output | 1 | Forwarding data available |
| fwd_stall | output | 1 | Matching store has no data yet |
| fwd_data | output | DW | Forwarded data |
| rp_valid | input | 1 | External probe request |
| rp_addr | input | AW | External probe address |
| rp_hit | output | 1 | Probe matched a graduated entry |
| rp_data | output | DW | Data of the matched graduated entry |

## Verification
Two stores share an address, with a different store between them. Lookups are then made with tags on either side of the younger one. A design that picked the oldest match, or ignored the tag bound, would return the wrong data. A flush is raised together with an allocation request, and later together with a retirement, so the queue mixes surviving graduated entries with discarded speculative ones. A design that rewound too far, or too little, would either lose stores from the scoreboard's drain sequence or leak flushed stores into it. The queue is filled to capacity against a stalled cache port and wraps around, which exposes pointer wrap and full-flag errors. A store is filled with its address but not its data, which separates a stall from a premature hit. The external probe is compared against a speculative twin address, so a probe that ignored graduation would show the speculative data.

// File: rtl/stq_pkg.sv
package stq_pkg;
  localparam int unsigned RETIRE_W   = 2;
  localparam int unsigned MAX_RETIRE = 2;
endpackage

// File: rtl/stq_ptr_ctrl.sv
module stq_ptr_ctrl
  import stq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  localparam int unsigned PW = $clog2(DEPTH) + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_req,
  input  logic                flush,
  input  logic                drain_fire,
  input  logic [RETIRE_W-1:0] retire_cnt,
  output logic [PW-1:0]       head_q,
  output logic [PW-1:0]       grad_q,
  output logic [PW-1:0]       tail_q,
  output logic [PW-1:0]       occ,
  output logic                full,
  output logic                alloc_fire
);
  logic [PW-1:0] grad_nxt;

  assign grad_nxt   = grad_q + PW'(retire_cnt);
  assign occ        = tail_q - head_q;
  assign full       = (occ == PW'(DEPTH));
  assign alloc_fire = alloc_req && !full && !flush;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      head_q <= '0;
      grad_q <= '0;
      tail_q <= '0;
    end else begin
      if (drain_fire) head_q <= head_q + PW'(1);
      grad_q <= grad_nxt;
      if (flush)           tail_q <= grad_nxt;
      else if (alloc_fire) tail_q <= tail_q + PW'(1);
    end
  end
endmodule

// File: rtl/stq_entry_array.sv
module stq_entry_array #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW = $clog2(DEPTH)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       alloc_fire,
  input  logic [IW-1:0]              alloc_idx,
  input  logic                       a_fill,
  input  logic [IW-1:0]              a_idx,
  input  logic [AW-1:0]              a_val,
  input  logic                       d_fill,
  input  logic [IW-1:0]              d_idx,
  input  logic [DW-1:0]              d_val,
  output logic [DEPTH-1:0][AW-1:0]   addr_arr,
  output logic [DEPTH-1:0][DW-1:0]   data_arr,
  output logic [DEPTH-1:0]           addr_ok,
  output logic [DEPTH-1:0]           data_ok
);
  for (genvar e = 0; e < DEPTH; e++) begin : g_ent
    logic          take_alloc, take_a, take_d;
    logic          a_ok_q, d_ok_q;
    logic [AW-1:0] a_q;
    logic [DW-1:0] d_q;

    assign take_alloc = alloc_fire && (alloc_idx == IW'(e));
    assign take_a     = a_fill && (a_idx == IW'(e));
    assign take_d     = d_fill && (d_idx == IW'(e));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        a_ok_q <= 1'b0;
        d_ok_q <= 1'b0;
      end else begin
        if (take_alloc)  a_ok_q <= 1'b0;
        else if (take_a) a_ok_q <= 1'b1;
        if (take_alloc)  d_ok_q <= 1'b0;
        else if (take_d) d_ok_q <= 1'b1;
      end
    end

    always_ff @(posedge clk) begin
      if (take_a) a_q <= a_val;
      if (take_d) d_q <= d_val;
    end

    assign addr_arr[e] = a_q;
    assign data_arr[e] = d_q;
    assign addr_ok[e]  = a_ok_q;
    assign data_ok[e]  = d_ok_q;
  end
endmodule

// File: rtl/stq_youngest_match.sv
module stq_youngest_match #(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 32,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned PW = IW + 1
) (
  input  logic [PW-1:0]             start_ptr,
  input  logic [PW-1:0]             span,
  input  logic [AW-1:0]             key,
  input  logic [DEPTH-1:0][AW-1:0]  addr_arr,
  input  logic [DEPTH-1:0]          addr_ok,
  output logic                      found,
  output logic [IW-1:0]             idx
);
  logic [PW-1:0] pos;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    pos   = '0;
    for (int k = 0; k < DEPTH; k++) begin
      pos = start_ptr + span - PW'(1) - PW'(k);
      if (!found && (PW'(k) < span) && addr_ok[pos[IW-1:0]] &&
          (addr_arr[pos[IW-1:0]] == key)) begin
        found = 1'b1;
        idx   = pos[IW-1:0];
      end
    end
  end
endmodule

// File: rtl/spec_store_queue.sv
module spec_store_queue
  import stq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned PW = IW + 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                alloc_valid,
  output logic                alloc_ready,
  output logic [PW-1:0]       alloc_tag,
  input  logic                st_addr_valid,
  input  logic [IW-1:0]       st_addr_idx,
  input  logic [AW-1:0]       st_addr,
  input  logic                st_data_valid,
  input  logic [IW-1:0]       st_data_idx,
  input  logic [DW-1:0]       st_data,
  input  logic [RETIRE_W-1:0] retire_cnt,
  input  logic                flush,
  output logic                full,
  output logic                drain_valid,
  input  logic                drain_ready,
  output logic [AW-1:0]       drain_addr,
  output logic [DW-1:0]       drain_data,
  input  logic                ld_valid,
  input  logic [PW-1:0]       ld_tag,
  input  logic [AW-1:0]       ld_addr,
  output logic                fwd_hit,
  output logic                fwd_stall,
  output logic [DW-1:0]       fwd_data,
  input  logic                rp_valid,
  input  logic [AW-1:0]       rp_addr,
  output logic                rp_hit,
  output logic [DW-1:0]       rp_data
);
  logic [PW-1:0]             head_q, grad_q, tail_q, occ;
  logic                      alloc_fire, drain_fire;
  logic [DEPTH-1:0][AW-1:0]  addr_arr;
  logic [DEPTH-1:0][DW-1:0]  data_arr;
  logic [DEPTH-1:0]          addr_ok, data_ok;
  logic [PW-1:0]             ld_dist, ld_span, grad_span;
  logic                      ld_found, rp_found;
  logic [IW-1:0]             ld_idx, rp_idx, head_idx;

  stq_ptr_ctrl #(.DEPTH(DEPTH)) u_ptr (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_req  (alloc_valid),
    .flush      (flush),
    .drain_fire (drain_fire),
    .retire_cnt (retire_cnt),
    .head_q     (head_q),
    .grad_q     (grad_q),
    .tail_q     (tail_q),
    .occ        (occ),
    .full       (full),
    .alloc_fire (alloc_fire)
  );

  stq_entry_array #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_ent (
    .clk        (clk),
    .rst_n      (rst_n),
    .alloc_fire (alloc_fire),
    .alloc_idx  (tail_q[IW-1:0]),
    .a_fill     (st_addr_valid),
    .a_idx      (st_addr_idx),
    .a_val      (st_addr),
    .d_fill     (st_data_valid),
    .d_idx      (st_data_idx),
    .d_val      (st_data),
    .addr_arr   (addr_arr),
    .data_arr   (data_arr),
    .addr_ok    (addr_ok),
    .data_ok    (data_ok)
  );

  // Loads see entries from the head up to their own tag; a tag outside
  // the occupied window sees nothing.
  assign ld_dist   = ld_tag - head_q;
  assign ld_span   = (ld_dist > occ) ? '0 : ld_dist;
  assign grad_span = grad_q - head_q;

  stq_youngest_match #(.DEPTH(DEPTH), .AW(AW)) u_ld_srch (
    .start_ptr (head_q),
    .span      (ld_span),
    .key       (ld_addr),
    .addr_arr  (addr_arr),
    .addr_ok   (addr_ok),
    .found     (ld_found),
    .idx       (ld_idx)
  );

  stq_youngest_match #(.DEPTH(DEPTH), .AW(AW)) u_rp_srch (
    .start_ptr (head_q),
    .span      (grad_span),
    .key       (rp_addr),
    .addr_arr  (addr_arr),
    .addr_ok   (addr_ok),
    .found     (rp_found),
    .idx       (rp_idx)
  );

  assign fwd_hit   = ld_valid && ld_found && data_ok[ld_idx];
  assign fwd_stall = ld_valid && ld_found && !data_ok[ld_idx];
  assign fwd_data  = data_arr[ld_idx];

  assign rp_hit  = rp_valid && rp_found && data_ok[rp_idx];
  assign rp_data = data_arr[rp_idx];

  assign head_idx    = head_q[IW-1:0];
  assign drain_valid = (head_q != grad_q);
  assign drain_fire  = drain_valid && drain_ready;
  assign drain_addr  = addr_arr[head_idx];
  assign drain_data  = data_arr[head_idx];

  assign alloc_ready = !full;
  assign alloc_tag   = tail_q;
endmodule

// File: rtl/stq_checker.sv
module stq_checker
  import stq_pkg::*;
#(
  parameter int unsigned DEPTH = 8,
  parameter int unsigned AW    = 32,
  parameter int unsigned DW    = 32,
  localparam int unsigned IW = $clog2(DEPTH),
  localparam int unsigned PW = IW + 1
) (
  input logic                clk,
  input logic                rst_n,
  input logic                alloc_ready,
  input logic                full,
  input logic                flush,
  input logic [RETIRE_W-1:0] retire_cnt,
  input logic                drain_valid,
  input logic                drain_ready,
  input logic [AW-1:0]       drain_addr,
  input logic [DW-1:0]       drain_data,
  input logic                fwd_hit,
  input logic                fwd_stall,
  input logic                rp_hit,
  input logic [PW-1:0]       head_q,
  input logic [PW-1:0]       grad_q,
  input logic [PW-1:0]       tail_q,
  input logic [DEPTH-1:0]    addr_ok,
  input logic [DEPTH-1:0]    data_ok
);
  logic [IW-1:0] g0, g1, h0;
  logic [PW-1:0] spec_cnt, grad_cnt, live_cnt;

  assign g0       = grad_q[IW-1:0];
  assign g1       = g0 + IW'(1);
  assign h0       = head_q[IW-1:0];
  assign spec_cnt = tail_q - grad_q;
  assign grad_cnt = grad_q - head_q;
  assign live_cnt = tail_q - head_q;

  p_full_no_ready_r3: assert property (@(posedge clk) disable iff (!rst_n)
    full |-> !alloc_ready);

  p_order_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (grad_cnt <= live_cnt) && (live_cnt <= PW'(DEPTH)));

  p_retire_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_cnt <= RETIRE_W'(MAX_RETIRE)) && (PW'(retire_cnt) <= spec_cnt));

  p_retire_first_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_cnt != '0) |-> (addr_ok[g0] && data_ok[g0]));

  p_retire_second_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (retire_cnt == RETIRE_W'(2)) |-> (addr_ok[g1] && data_ok[g1]));

  p_drain_filled_r5: assert property (@(posedge clk) disable iff (!rst_n)
    drain_valid |-> (addr_ok[h0] && data_ok[h0]));

  p_drain_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (drain_valid && !drain_ready) |=>
      (drain_valid && $stable(drain_addr) && $stable(drain_data)));

  p_flush_cut_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (tail_q == grad_q));

  p_fwd_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(fwd_hit && fwd_stall));

  p_remote_grad_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rp_hit |-> (grad_cnt != '0));
endmodule

bind spec_store_queue stq_checker #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) u_stq_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .alloc_ready (alloc_ready),
  .full        (full),
  .flush       (flush),
  .retire_cnt  (retire_cnt),
  .drain_valid (drain_valid),
  .drain_ready (drain_ready),
  .drain_addr  (drain_addr),
  .drain_data  (drain_data),
  .fwd_hit     (fwd_hit),
  .fwd_stall   (fwd_stall),
  .rp_hit      (rp_hit),
  .head_q      (head_q),
  .grad_q      (grad_q),
  .tail_q      (tail_q),
  .addr_ok     (addr_ok),
  .data_ok     (data_ok)
);

// File: tb/spec_store_queue_tb.sv
`timescale 1ns / 100ps
module spec_store_queue_tb_top;
  localparam int unsigned DEPTH = 8;
  localparam int unsigned AW = 32;
  localparam int unsigned DW = 32;
  localparam int unsigned IW = 3;
  localparam int unsigned PW = 4;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic          rst_n;
  logic          alloc_valid, alloc_ready;
  logic [PW-1:0] alloc_tag;
  logic          st_addr_valid, st_data_valid;
  logic [IW-1:0] st_addr_idx, st_data_idx;
  logic [AW-1:0] st_addr;
  logic [DW-1:0] st_data;
  logic [1:0]    retire_cnt;
  logic          flush, full;
  logic          drain_valid, drain_ready;
  logic [AW-1:0] drain_addr;
  logic [DW-1:0] drain_data;
  logic          ld_valid;
  logic [PW-1:0] ld_tag;
  logic [AW-1:0] ld_addr;
  logic          fwd_hit, fwd_stall;
  logic [DW-1:0] fwd_data;
  logic          rp_valid;
  logic [AW-1:0] rp_addr;
  logic          rp_hit;
  logic [DW-1:0] rp_data;

  spec_store_queue #(.DEPTH(DEPTH), .AW(AW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .alloc_valid(alloc_valid), .alloc_ready(alloc_ready), .alloc_tag(alloc_tag),
    .st_addr_valid(st_addr_valid), .st_addr_idx(st_addr_idx), .st_addr(st_addr),
    .st_data_valid(st_data_valid), .st_data_idx(st_data_idx), .st_data(st_data),
    .retire_cnt(retire_cnt), .flush(flush), .full(full),
    .drain_valid(drain_valid), .drain_ready(drain_ready),
    .drain_addr(drain_addr), .drain_data(drain_data),
    .ld_valid(ld_valid), .ld_tag(ld_tag), .ld_addr(ld_addr),
    .fwd_hit(fwd_hit), .fwd_stall(fwd_stall), .fwd_data(fwd_data),
    .rp_valid(rp_valid), .rp_addr(rp_addr), .rp_hit(rp_hit), .rp_data(rp_data)
  );

  int vectors = 0;
  int miscompares = 0;
  logic [63:0] pend[$];
  logic [63:0] expq[$];
  logic [PW-1:0] tail_m = '0;
  logic [PW-1:0] grad_m = '0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // Scoreboard monitor: compares each accepted cache write with the queue.
  always begin
    @(negedge clk);
    #1;
    if (rst_n && drain_valid && drain_ready) begin
      if (expq.size() == 0) begin
        chk("R6 drain of non-graduated store", {drain_addr, drain_data}, 64'h0);
      end else begin
        logic [63:0] e;
        e = expq.pop_front();
        chk("R5 drain order", {drain_addr, drain_data}, e);
      end
    end
  end

  initial begin
    #(200000 * 5);
    vectors++;
    miscompares++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  task automatic step();
    @(negedge clk);
    alloc_valid = 0; st_addr_valid = 0; st_data_valid = 0;
    retire_cnt = 0; flush = 0; ld_valid = 0; rp_valid = 0;
  endtask

  task automatic alloc_st(input logic [31:0] a, input logic [31:0] d, output logic [IW-1:0] idx);
    step();
    alloc_valid = 1;
    #1;
    chk("R2 allocation tag", 64'(alloc_tag), 64'(tail_m));
    idx = alloc_tag[IW-1:0];
    pend.push_back({a, d});
    tail_m = tail_m + 1'b1;
  endtask

  task automatic fill(input logic [IW-1:0] idx, input logic [31:0] a, input logic [31:0] d,
                      input bit do_a, input bit do_d);
    step();
    st_addr_valid = do_a; st_addr_idx = idx; st_addr = a;
    st_data_valid = do_d; st_data_idx = idx; st_data = d;
  endtask

  task automatic store(input logic [31:0] a, input logic [31:0] d);
    logic [IW-1:0] idx;
    alloc_st(a, d, idx);
    fill(idx, a, d, 1, 1);
  endtask

  task automatic retire(input int n);
    step();
    retire_cnt = 2'(n);
    for (int i = 0; i < n; i++) expq.push_back(pend.pop_front());
    grad_m = grad_m + PW'(n);
  endtask

  task automatic flush_op(input int n, input bit with_alloc);
    step();
    flush = 1;
    retire_cnt = 2'(n);
    alloc_valid = with_alloc;
    for (int i = 0; i < n; i++) expq.push_back(pend.pop_front());
    pend.delete();
    grad_m = grad_m + PW'(n);
    tail_m = grad_m;
  endtask

  task automatic lookup(input logic [PW-1:0] tag, input logic [31:0] a, input bit e_hit,
                        input bit e_stall, input logic [31:0] e_data, input string req);
    step();
    ld_valid = 1; ld_tag = tag; ld_addr = a;
    #1;
    chk({req, " hit"}, 64'(fwd_hit), 64'(e_hit));
    chk({req, " stall"}, 64'(fwd_stall), 64'(e_stall));
    if (e_hit) chk({req, " data"}, 64'(fwd_data), 64'(e_data));
  endtask

  task automatic probe(input logic [31:0] a, input bit e_hit, input logic [31:0] e_data,
                       input string req);
    step();
    rp_valid = 1; rp_addr = a;
    #1;
    chk({req, " hit"}, 64'(rp_hit), 64'(e_hit));
    if (e_hit) chk({req, " data"}, 64'(rp_data), 64'(e_data));
  endtask

  task automatic wait_drained(input string req);
    for (int i = 0; i < 40; i++) begin
      step();
      if (expq.size() == 0) break;
    end
    step();
    #1;
    chk({req, " queue drained"}, 64'(expq.size()), 64'h0);
    chk({req, " drain_valid idle"}, 64'(drain_valid), 64'h0);
  endtask

  initial begin
    logic [IW-1:0] idx3;
    rst_n = 0;
    alloc_valid = 0; st_addr_valid = 0; st_data_valid = 0;
    st_addr_idx = '0; st_data_idx = '0; st_addr = '0; st_data = '0;
    retire_cnt = 0; flush = 0; drain_ready = 0;
    ld_valid = 0; ld_tag = '0; ld_addr = '0; rp_valid = 0; rp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 alloc_ready", 64'(alloc_ready), 64'h1);
    chk("R1 full", 64'(full), 64'h0);
    chk("R1 drain_valid", 64'(drain_valid), 64'h0);
    chk("R1 alloc_tag", 64'(alloc_tag), 64'h0);

    // Three speculative stores, two to the same address
    store(32'h100, 32'h11);
    store(32'h200, 32'h22);
    store(32'h100, 32'h33);
    step(); #1;
    chk("R5 speculative head not offered", 64'(drain_valid), 64'h0);
    lookup(4'd3, 32'h100, 1, 0, 32'h33, "R8 youngest older match");
    lookup(4'd2, 32'h100, 1, 0, 32'h11, "R10 younger entry ignored");
    lookup(4'd3, 32'h300, 0, 0, 32'h0,  "R10 address mismatch");
    lookup(4'd1, 32'h200, 0, 0, 32'h0,  "R10 store at tag ignored");
    probe(32'h100, 0, 32'h0, "R11 speculative hidden");

    retire(2);
    step(); #1;
    chk("R4 graduated head offered", 64'(drain_valid), 64'h1);
    chk("R5 head address", 64'(drain_addr), 64'h100);
    chk("R5 head data", 64'(drain_data), 64'h11);
    probe(32'h100, 1, 32'h11, "R11 graduated only");
    probe(32'h200, 1, 32'h22, "R11 graduated hit");
    lookup(4'd3, 32'h100, 1, 0, 32'h33, "R8 across graduated");

    // Address filled, data pending
    alloc_st(32'h400, 32'h44, idx3);
    fill(idx3, 32'h400, 32'h0, 1, 0);
    lookup(4'd4, 32'h400, 0, 1, 32'h0, "R9 data missing");
    fill(idx3, 32'h0, 32'h44, 0, 1);
    lookup(4'd4, 32'h400, 1, 0, 32'h44, "R9 data filled");

    // Flush with a same-cycle allocation request
    flush_op(0, 1);
    step(); #1;
    chk("R6 tail at graduation", 64'(alloc_tag), 64'(tail_m));
    chk("R7 allocation ignored", 64'(alloc_tag), 64'h2);
    lookup(4'd4, 32'h400, 0, 0, 32'h0, "R6 flushed entry gone");
    lookup(4'd2, 32'h100, 1, 0, 32'h11, "R6 graduated kept");
    drain_ready = 1;
    wait_drained("R6 first flush");

    // Fill to capacity against a stalled cache port, wrapping the ring
    drain_ready = 0;
    for (int i = 0; i < DEPTH; i++) begin
      step(); #1;
      chk("R3 ready below capacity", 64'(alloc_ready), 64'h1);
      store(32'h1000 + 32'(i), 32'hA0 + 32'(i));
    end
    step(); alloc_valid = 1; #1;
    chk("R3 full flag", 64'(full), 64'h1);
    chk("R3 alloc_ready low", 64'(alloc_ready), 64'h0);
    step(); #1;
    chk("R3 request ignored when full", 64'(alloc_tag), 64'(tail_m));
    drain_ready = 1;
    for (int i = 0; i < DEPTH / 2; i++) retire(2);
    wait_drained("R5 wrapped drain");
    chk("R3 full cleared", 64'(full), 64'h0);

    // Flush combined with retirement
    drain_ready = 0;
    store(32'h500, 32'h55);
    store(32'h600, 32'h66);
    store(32'h700, 32'h77);
    store(32'h800, 32'h88);
    retire(1);
    flush_op(2, 0);
    step(); #1;
    chk("R6 retire applied before flush", 64'(alloc_tag), 64'(tail_m));
    chk("R6 graduated survive flush", 64'(drain_valid), 64'h1);
    probe(32'h800, 0, 32'h0, "R11 flushed store invisible");
    drain_ready = 1;
    wait_drained("R6 second flush");

    finish_run();
  end
endmodule